// File: doc/BRIEF.md
# Host Bus Slave Port

This block is the host-facing slave port of a network controller. A host processor reaches a small banked register file through it, and a DMA engine reaches the packet buffer through it. Each access is framed by an active-low chip select (or an active-low DMA acknowledge), an active-low read or write strobe and a 4-bit address. The port decodes the target and works out which byte lanes of the 16-bit system bus carry data. It then answers with a ready handshake whose polarity is set by a strap input.

Register accesses complete at once. Accesses made while the DMA acknowledge is low go to a buffer stub port, and that port may stall. If the buffer side does not answer within a fixed number of clock cycles, the port completes the access anyway. It then sets a sticky error bit for the direction of the access, which can raise the active-low interrupt. A DMA request output follows the buffer side's need for service until the host's end-of-process input is seen, and after that it stays low.

Address map, the same in every bank:
- Byte 0xF is the configuration byte. Bits 1:0 select the bank and bit 2 selects byte mode.
- Byte 0xE holds the error status. Bit 0 is the read timeout flag and bit 1 is the write timeout flag.
- Byte 0xD holds the interrupt mask, with its bits matching the status bits.
- Bytes 0x0 to 0xC are general storage, kept separately for each bank.

In word mode a 16-bit access hits the even byte on lane 7:0 and the odd byte on lane 15:8.

Top module: `hbs_host_port`

## Requirements
- R1: `word_mode_o` is the inverse of configuration bit 2 (1 means word mode). After reset the port is in word mode with bank 0 selected.
- R2: In word mode, `bhe_n`=0 with `addr[0]`=0 is a 16-bit transfer. The even byte travels on bits 7:0 and the odd byte on bits 15:8.
- R3: In word mode, `bhe_n`=0 with `addr[0]`=1 is a byte transfer on bits 15:8. On a read of this kind, bits 7:0 of `rdata` are zero.
- R4: In word mode, `bhe_n`=1 with `addr[0]`=0 is a byte transfer on bits 7:0. On a read of this kind, bits 15:8 are zero.
- R5: In word mode, `bhe_n`=1 with `addr[0]`=1 is reserved. A write of this kind changes nothing, a read returns zero, and no buffer request is issued.
- R6: In byte mode every transfer uses bits 7:0, whatever `bhe_n` is, and `addr[0]` selects the byte.
- R7: Bytes 0x0 to 0xC are held separately for each bank named by configuration bits 1:0. Bytes 0xD to 0xF are shared by all banks.
- R8: With `dack_n` low, an access goes to the buffer port instead of a register. `buf_be` gives the lanes in use (bit 1 is the upper lane) and follows the same lane rules. Ready follows one cycle after `buf_ack`, so a register access completes one cycle after the strobe.
- R9: If `buf_ack` does not arrive, ready is forced TIMEOUT+1 cycles after the strobe, and read data is zero. Status bit 0 is set for a read and status bit 1 for a write.
- R10: Status bits stay set until the host writes 1 to them. `int_n` is low exactly when a status bit is set and its mask bit is 1.
- R11: `rdy` is active high when `rdy_pol`=1 and active low when `rdy_pol`=0. It stays active until the strobe is released.
- R12: `dreq` follows `dma_need` until `eop_n` is seen low. After that it stays low until reset.
- R13: `data_oe` is high only while a read strobe is low together with chip select or DMA acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| dack_n | input | 1 | DMA acknowledge, active low; selects the buffer port |
| eop_n | input | 1 | End of DMA process, active low |
| addr | input | 4 | Register byte address |
| bhe_n | input | 1 | Byte-high enable, active low |
| wdata | input | 16 | Write data from the host bus |
| rdata | output | 16 | Read data to the host bus |
| data_oe | output | 1 | Host data bus drive enable |
| rdy_pol | input | 1 | Ready polarity strap (1 = active high) |
| rdy | output | 1 | Ready handshake |
| int_n | output | 1 | Interrupt, active low |
| word_mode_o | output | 1 | 1 when the port is in word mode |
| dma_need | input | 1 | Buffer side wants DMA service |
| dreq | output | 1 | DMA request |
| buf_req | output | 1 | Buffer port access pending |
| buf_we | output | 1 | Buffer access is a write |
| buf_be | output | 2 | Buffer lanes in use (bit 1 upper) |
| buf_wdata | output | 16 | Buffer write data |
| buf_rdata | input | 16 | Buffer read data |
| buf_ack | input | 1 | Buffer side completes the access |

## Verification
The hardest state to reach is a stalled buffer access that runs into the timeout. The bench's buffer stub acknowledges only after a programmable number of stalled cycles. Setting that number very high forces the timeout path, and setting it low exercises normal completion. The bench measures the strobe-to-ready latency for both. Reaching the interrupt takes three further steps: programming the mask, causing a timeout in each direction, and clearing the error bits one at a time.

// File: rtl/hbs_pkg.sv
package hbs_pkg;

    typedef enum logic [1:0] {
        LANE_NONE = 2'd0,
        LANE_LO   = 2'd1,
        LANE_HI   = 2'd2,
        LANE_WORD = 2'd3
    } lane_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_DONE = 2'd2
    } port_st_e;

    typedef struct packed {
        logic  is_read;
        lane_e lane;
    } acc_t;

    localparam logic [3:0] ADDR_CFG  = 4'hF;
    localparam logic [3:0] ADDR_STAT = 4'hE;
    localparam logic [3:0] ADDR_MASK = 4'hD;
    localparam int         CFG_BYTE_BIT = 2;

    // Lane choice from bus mode, byte-high enable and address bit 0.
    function automatic lane_e pick_lane(input logic byte_mode, input logic bhe_n, input logic a0);
        lane_e l;
        if (byte_mode)            l = LANE_LO;
        else if (!bhe_n && !a0)   l = LANE_WORD;
        else if (!bhe_n && a0)    l = LANE_HI;
        else if (bhe_n && !a0)    l = LANE_LO;
        else                      l = LANE_NONE;
        return l;
    endfunction

    function automatic logic [1:0] lane_be(input lane_e l);
        logic [1:0] be;
        case (l)
            LANE_WORD: be = 2'b11;
            LANE_HI:   be = 2'b10;
            LANE_LO:   be = 2'b01;
            default:   be = 2'b00;
        endcase
        return be;
    endfunction

    function automatic logic [15:0] lane_mask_rd(input lane_e l, input logic [15:0] raw);
        logic [15:0] d;
        case (l)
            LANE_WORD: d = raw;
            LANE_HI:   d = {raw[15:8], 8'h00};
            LANE_LO:   d = {8'h00, raw[7:0]};
            default:   d = 16'h0000;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/hbs_lane_steer.sv
module hbs_lane_steer
    import hbs_pkg::*;
(
    input  lane_e       lane,
    input  logic        a0,
    input  logic [15:0] wdata,
    input  logic [7:0]  rd_even,
    input  logic [7:0]  rd_odd,
    output logic        we_even,
    output logic        we_odd,
    output logic [7:0]  wb_even,
    output logic [7:0]  wb_odd,
    output logic [15:0] rdata
);
    always_comb begin
        we_even = 1'b0;
        we_odd  = 1'b0;
        wb_even = wdata[7:0];
        wb_odd  = wdata[15:8];
        rdata   = 16'h0000;
        case (lane)
            LANE_WORD: begin
                we_even = 1'b1;
                we_odd  = 1'b1;
                rdata   = {rd_odd, rd_even};
            end
            LANE_HI: begin
                we_odd = 1'b1;
                rdata  = {rd_odd, 8'h00};
            end
            LANE_LO: begin
                we_even = !a0;
                we_odd  = a0;
                wb_odd  = wdata[7:0];
                rdata   = {8'h00, a0 ? rd_odd : rd_even};
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/hbs_regfile.sv
module hbs_regfile
    import hbs_pkg::*;
#(
    parameter int NBANK = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] pair,
    input  logic       we_even,
    input  logic       we_odd,
    input  logic [7:0] wb_even,
    input  logic [7:0] wb_odd,
    input  logic       set_rd_err,
    input  logic       set_wr_err,
    output logic [7:0] rd_even,
    output logic [7:0] rd_odd,
    output logic       byte_mode,
    output logic       irq
);
    localparam int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1;
    localparam int NBYTE  = 16;

    logic [7:0]        store [NBANK][NBYTE];
    logic [7:0]        cfg_q;
    logic [7:0]        mask_q;
    logic [1:0]        stat_q;
    logic [BANK_W-1:0] bank;
    logic [3:0]        idx_e;
    logic [3:0]        idx_o;
    logic [1:0]        stat_clr;

    assign bank      = cfg_q[BANK_W-1:0];
    assign byte_mode = cfg_q[CFG_BYTE_BIT];
    assign idx_e     = {pair, 1'b0};
    assign idx_o     = {pair, 1'b1};
    assign stat_clr  = (we_even && idx_e == ADDR_STAT) ? wb_even[1:0] : 2'b00;
    assign irq       = |(stat_q & mask_q[1:0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            mask_q <= '0;
            stat_q <= '0;
            for (int b = 0; b < NBANK; b++)
                for (int i = 0; i < NBYTE; i++)
                    store[b][i] <= '0;
        end else begin
            stat_q <= (stat_q & ~stat_clr) | {set_wr_err, set_rd_err};
            if (we_even && idx_e != ADDR_STAT)
                store[bank][idx_e] <= wb_even;
            if (we_odd) begin
                case (idx_o)
                    ADDR_CFG:  cfg_q  <= wb_odd;
                    ADDR_MASK: mask_q <= wb_odd;
                    default:   store[bank][idx_o] <= wb_odd;
                endcase
            end
        end
    end

    always_comb begin
        rd_even = (idx_e == ADDR_STAT) ? {6'b0, stat_q} : store[bank][idx_e];
        case (idx_o)
            ADDR_CFG:  rd_odd = cfg_q;
            ADDR_MASK: rd_odd = mask_q;
            default:   rd_odd = store[bank][idx_o];
        endcase
    end
endmodule

// File: rtl/hbs_timeout.sv
module hbs_timeout #(
    parameter int TIMEOUT = 48
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expire
);
    localparam int CNT_W = $clog2(TIMEOUT + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run) cnt_q <= '0;
        else             cnt_q <= cnt_q + 1'b1;
    end

    assign expire = run && (cnt_q == CNT_W'(TIMEOUT - 1));
endmodule

// File: rtl/hbs_host_port.sv
module hbs_host_port
    import hbs_pkg::*;
#(
    parameter int NBANK   = 4,
    parameter int TIMEOUT = 48
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cs_n,
    input  logic        rd_n,
    input  logic        wr_n,
    input  logic        dack_n,
    input  logic        eop_n,
    input  logic [3:0]  addr,
    input  logic        bhe_n,
    input  logic [15:0] wdata,
    output logic [15:0] rdata,
    output logic        data_oe,
    input  logic        rdy_pol,
    output logic        rdy,
    output logic        int_n,
    output logic        word_mode_o,
    input  logic        dma_need,
    output logic        dreq,
    output logic        buf_req,
    output logic        buf_we,
    output logic [1:0]  buf_be,
    output logic [15:0] buf_wdata,
    input  logic [15:0] buf_rdata,
    input  logic        buf_ack
);
    port_st_e    st_q;
    acc_t        acc_q;
    logic [15:0] wdata_q;
    logic [15:0] rd_q;
    logic        eop_seen_q;

    logic        sel, rd_act, wr_act, strobe;
    logic        byte_mode, irq, expire;
    lane_e       lane_now;
    logic        we_even, we_odd;
    logic [7:0]  wb_even, wb_odd, rd_even, rd_odd;
    logic [15:0] reg_rdata;
    logic        start, reg_we, set_rd_err, set_wr_err;

    assign sel      = !cs_n || !dack_n;
    assign rd_act   = !rd_n && wr_n;
    assign wr_act   = !wr_n && rd_n;
    assign strobe   = sel && (rd_act || wr_act);
    assign lane_now = pick_lane(byte_mode, bhe_n, addr[0]);
    assign start    = (st_q == ST_IDLE) && strobe;
    assign reg_we   = start && wr_act && dack_n;

    hbs_lane_steer u_steer (
        .lane    (lane_now),
        .a0      (addr[0]),
        .wdata   (wdata),
        .rd_even (rd_even),
        .rd_odd  (rd_odd),
        .we_even (we_even),
        .we_odd  (we_odd),
        .wb_even (wb_even),
        .wb_odd  (wb_odd),
        .rdata   (reg_rdata)
    );

    hbs_regfile #(.NBANK(NBANK)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .pair       (addr[3:1]),
        .we_even    (we_even && reg_we),
        .we_odd     (we_odd && reg_we),
        .wb_even    (wb_even),
        .wb_odd     (wb_odd),
        .set_rd_err (set_rd_err),
        .set_wr_err (set_wr_err),
        .rd_even    (rd_even),
        .rd_odd     (rd_odd),
        .byte_mode  (byte_mode),
        .irq        (irq)
    );

    hbs_timeout #(.TIMEOUT(TIMEOUT)) u_tmo (
        .clk    (clk),
        .rst    (rst),
        .run    (st_q == ST_WAIT),
        .expire (expire)
    );

    assign set_rd_err = (st_q == ST_WAIT) && strobe && !buf_ack && expire && acc_q.is_read;
    assign set_wr_err = (st_q == ST_WAIT) && strobe && !buf_ack && expire && !acc_q.is_read;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            acc_q   <= '{is_read: 1'b0, lane: LANE_NONE};
            wdata_q <= '0;
            rd_q    <= '0;
        end else begin
            case (st_q)
                ST_IDLE: if (strobe) begin
                    acc_q   <= '{is_read: rd_act, lane: lane_now};
                    wdata_q <= wdata;
                    if (!dack_n && lane_now != LANE_NONE) begin
                        st_q <= ST_WAIT;
                    end else begin
                        rd_q <= (rd_act && dack_n) ? reg_rdata : 16'h0000;
                        st_q <= ST_DONE;
                    end
                end
                ST_WAIT: begin
                    if (!strobe) begin
                        st_q <= ST_IDLE;
                    end else if (buf_ack) begin
                        rd_q <= acc_q.is_read ? lane_mask_rd(acc_q.lane, buf_rdata) : 16'h0000;
                        st_q <= ST_DONE;
                    end else if (expire) begin
                        rd_q <= 16'h0000;
                        st_q <= ST_DONE;
                    end
                end
                ST_DONE: if (!strobe) st_q <= ST_IDLE;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         eop_seen_q <= 1'b0;
        else if (!eop_n) eop_seen_q <= 1'b1;
    end

    assign buf_req     = (st_q == ST_WAIT);
    assign buf_we      = buf_req && !acc_q.is_read;
    assign buf_be      = buf_req ? lane_be(acc_q.lane) : 2'b00;
    assign buf_wdata   = wdata_q;
    assign rdata       = rd_q;
    assign data_oe     = sel && !rd_n;
    assign rdy         = rdy_pol ? (st_q == ST_DONE) : (st_q != ST_DONE);
    assign int_n       = !irq;
    assign word_mode_o = !byte_mode;
    assign dreq        = dma_need && !eop_seen_q;
endmodule

// File: rtl/hbs_host_port_chk.sv
module hbs_host_port_chk #(
    parameter int TIMEOUT = 48
) (
    input logic       clk,
    input logic       rst,
    input logic       cs_n,
    input logic       rd_n,
    input logic       wr_n,
    input logic       dack_n,
    input logic       eop_n,
    input logic       rdy_pol,
    input logic       rdy,
    input logic       dreq,
    input logic       buf_req,
    input logic       buf_ack,
    input logic [1:0] buf_be,
    input logic       word_mode_o
);
    logic        rdy_act;
    logic        strobe;
    logic        eop_mark;
    logic [31:0] stall_run;

    assign rdy_act = rdy_pol ? rdy : !rdy;
    assign strobe  = (!cs_n || !dack_n) && (!rd_n ^ !wr_n);

    always_ff @(posedge clk) begin
        if (rst) begin
            eop_mark  <= 1'b0;
            stall_run <= '0;
        end else begin
            if (!eop_n) eop_mark <= 1'b1;
            stall_run <= (buf_req && !buf_ack) ? stall_run + 1 : '0;
        end
    end

    assert_ready_after_strobe_R11: assert property (@(posedge clk) disable iff (rst)
        $rose(rdy_act) |-> $past(strobe));

    assert_dreq_drops_R12: assert property (@(posedge clk) disable iff (rst)
        !eop_n |=> !dreq);

    assert_dreq_stays_low_R12: assert property (@(posedge clk) disable iff (rst)
        eop_mark |-> !dreq);

    assert_buf_from_dack_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(buf_req) |-> $past(!dack_n));

    assert_timeout_bound_R9: assert property (@(posedge clk) disable iff (rst)
        buf_req |-> stall_run < TIMEOUT);

    assert_no_reserved_req_R5: assert property (@(posedge clk) disable iff (rst)
        buf_req |-> buf_be != 2'b00);

    assert_byte_mode_low_lane_R6: assert property (@(posedge clk) disable iff (rst)
        (buf_req && !word_mode_o) |-> buf_be == 2'b01);
endmodule

bind hbs_host_port hbs_host_port_chk #(.TIMEOUT(TIMEOUT)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cs_n        (cs_n),
    .rd_n        (rd_n),
    .wr_n        (wr_n),
    .dack_n      (dack_n),
    .eop_n       (eop_n),
    .rdy_pol     (rdy_pol),
    .rdy         (rdy),
    .dreq        (dreq),
    .buf_req     (buf_req),
    .buf_ack     (buf_ack),
    .buf_be      (buf_be),
    .word_mode_o (word_mode_o)
);

// File: tb/test_hbs_host_port.sv
`timescale 1ns/100ps
module test_hbs_host_port;
    localparam int TMO = 48;

    logic clk = 1'b0;
    logic rst;
    logic cs_n, rd_n, wr_n, dack_n, eop_n, bhe_n, rdy_pol, dma_need, buf_ack;
    logic [3:0]  addr;
    logic [15:0] wdata, buf_rdata;
    logic [15:0] rdata, buf_wdata;
    logic        data_oe, rdy, int_n, word_mode_o, dreq, buf_req, buf_we;
    logic [1:0]  buf_be;
    logic        rdy_act;

    always #2.5 clk = ~clk;

    hbs_host_port #(.NBANK(4), .TIMEOUT(TMO)) i_hbs_host_port (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .dack_n(dack_n),
        .eop_n(eop_n), .addr(addr), .bhe_n(bhe_n), .wdata(wdata), .rdata(rdata),
        .data_oe(data_oe), .rdy_pol(rdy_pol), .rdy(rdy), .int_n(int_n),
        .word_mode_o(word_mode_o), .dma_need(dma_need), .dreq(dreq), .buf_req(buf_req),
        .buf_we(buf_we), .buf_be(buf_be), .buf_wdata(buf_wdata), .buf_rdata(buf_rdata),
        .buf_ack(buf_ack)
    );

    assign rdy_act = rdy_pol ? rdy : !rdy;

    int n_chk = 0;
    int n_err = 0;

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // buffer stub: acknowledges after stall_lim stalled cycles
    int stall_lim = 0;
    int stall = 0;
    logic [15:0] cap_data;
    logic [1:0]  cap_be;
    assign buf_ack = buf_req && (stall >= stall_lim);
    always @(posedge clk) begin
        if (!buf_req)      stall <= 0;
        else if (!buf_ack) stall <= stall + 1;
        if (buf_req && buf_ack && buf_we) begin
            cap_data <= buf_wdata;
            cap_be   <= buf_be;
        end
    end

    // scoreboard
    typedef struct {
        logic [15:0] val;
        string       tag;
    } exp_t;
    exp_t exp_q[$];
    bit   mon_arm = 0;
    bit   mon_rd = 0;
    int   mon_lat = 0;
    int   last_lat = 0;
    logic last_rdy, last_oe;

    always @(negedge clk) begin
        if (mon_arm) begin
            mon_lat++;
            if (rdy_act) begin
                last_lat = mon_lat;
                last_rdy = rdy;
                last_oe  = data_oe;
                if (mon_rd) begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(e.tag, {16'h0, rdata}, {16'h0, e.val});
                end
                mon_arm = 0;
            end else if (mon_lat > 20000) begin
                check("monitor: no ready", 0, 1);
                mon_arm = 0;
            end
        end
    end

    task automatic acc(bit is_rd, bit dma, logic [3:0] a, logic b, logic [15:0] wd,
                       logic [15:0] ex, string tag);
        @(negedge clk);
        addr  = a;
        bhe_n = b;
        wdata = wd;
        if (dma) dack_n = 1'b0; else cs_n = 1'b0;
        if (is_rd) rd_n = 1'b0; else wr_n = 1'b0;
        if (is_rd) exp_q.push_back('{val: ex, tag: tag});
        #1;
        mon_rd  = is_rd;
        mon_lat = 0;
        mon_arm = 1;
        wait (!mon_arm);
        cs_n = 1'b1; dack_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check("watchdog expired", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        rst = 1; cs_n = 1; rd_n = 1; wr_n = 1; dack_n = 1; eop_n = 1; bhe_n = 1;
        addr = 0; wdata = 0; rdy_pol = 1; dma_need = 0; buf_rdata = 16'hA5C3;
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check("R11 reset ready idle", {31'h0, rdy}, 0);
        check("R10 reset int_n", {31'h0, int_n}, 1);
        check("R1 reset word mode", {31'h0, word_mode_o}, 1);
        check("R12 reset dreq", {31'h0, dreq}, 0);
        check("R13 idle data_oe", {31'h0, data_oe}, 0);

        // word and lane transfers, bank 0
        acc(0, 0, 4'h2, 0, 16'hBEEF, 0, "");
        acc(1, 0, 4'h2, 0, 0, 16'hBEEF, "R2 word read");
        check("R8 register latency", last_lat, 1);
        check("R13 data_oe on read", {31'h0, last_oe}, 1);
        acc(0, 0, 4'h4, 0, 16'h1234, 0, "");
        acc(0, 0, 4'h5, 0, 16'h77AB, 0, "");
        check("R13 data_oe on write", {31'h0, last_oe}, 0);
        acc(1, 0, 4'h4, 0, 0, 16'h7734, "R3 upper byte write");
        acc(1, 0, 4'h5, 0, 0, 16'h7700, "R3 upper byte read");
        acc(0, 0, 4'h4, 1, 16'hCC99, 0, "");
        acc(1, 0, 4'h4, 0, 0, 16'h7799, "R4 lower byte write");
        acc(1, 0, 4'h4, 1, 0, 16'h0099, "R4 lower byte read");
        acc(0, 0, 4'h5, 1, 16'h5555, 0, "");
        acc(1, 0, 4'h4, 0, 0, 16'h7799, "R5 reserved write ignored");
        acc(1, 0, 4'h5, 1, 0, 16'h0000, "R5 reserved read zero");

        // banks
        acc(0, 0, 4'hF, 0, 16'h0100, 0, "");
        acc(0, 0, 4'h2, 0, 16'h1111, 0, "");
        acc(1, 0, 4'h2, 0, 0, 16'h1111, "R7 bank 1 storage");
        acc(1, 0, 4'hF, 0, 0, 16'h0100, "R7 config shared");
        acc(0, 0, 4'hF, 0, 16'h0000, 0, "");
        acc(1, 0, 4'h2, 0, 0, 16'hBEEF, "R7 bank 0 kept");

        // byte mode
        acc(0, 0, 4'hF, 0, 16'h0400, 0, "");
        check("R1 byte mode pin", {31'h0, word_mode_o}, 0);
        acc(0, 0, 4'h3, 0, 16'h345A, 0, "");
        acc(1, 0, 4'h3, 0, 0, 16'h005A, "R6 odd byte on low lane");
        acc(1, 0, 4'h2, 1, 0, 16'h00EF, "R6 even byte on low lane");
        acc(0, 0, 4'hF, 1, 16'h0000, 0, "");
        check("R1 back to word mode", {31'h0, word_mode_o}, 1);
        acc(1, 0, 4'h2, 0, 0, 16'h5AEF, "R6 byte-mode write landed");

        // buffer port
        stall_lim = 3;
        acc(1, 1, 4'h0, 0, 0, 16'hA5C3, "R8 buffer word read");
        check("R8 buffer latency", last_lat, 5);
        acc(1, 1, 4'h1, 0, 0, 16'hA500, "R8 buffer upper read");
        stall_lim = 0;
        acc(0, 1, 4'h0, 1, 16'h1234, 0, "");
        check("R8 buffer write data", {16'h0, cap_data}, 32'h1234);
        check("R8 buffer write lanes", {30'h0, cap_be}, 1);
        check("R8 buffer no-stall latency", last_lat, 2);

        // timeout and interrupt
        stall_lim = 1000000;
        acc(1, 1, 4'h0, 0, 0, 16'h0000, "R9 timed-out read data");
        check("R9 read timeout latency", last_lat, TMO + 1);
        acc(1, 0, 4'hE, 1, 0, 16'h0001, "R9 read error bit");
        check("R10 masked int_n", {31'h0, int_n}, 1);
        acc(0, 0, 4'hD, 0, 16'h0300, 0, "");
        check("R10 unmasked int_n", {31'h0, int_n}, 0);
        acc(0, 1, 4'h0, 0, 16'h0F0F, 0, "");
        check("R9 write timeout latency", last_lat, TMO + 1);
        acc(1, 0, 4'hE, 1, 0, 16'h0003, "R9 write error bit");
        acc(0, 0, 4'hE, 1, 16'h0001, 0, "");
        acc(1, 0, 4'hE, 1, 0, 16'h0002, "R10 clear read error only");
        check("R10 int_n still low", {31'h0, int_n}, 0);
        acc(0, 0, 4'hE, 1, 16'h0002, 0, "");
        acc(1, 0, 4'hE, 1, 0, 16'h0000, "R10 all clear");
        check("R10 int_n released", {31'h0, int_n}, 1);
        stall_lim = 0;

        // ready polarity
        rdy_pol = 0;
        @(negedge clk);
        check("R11 low-active idle level", {31'h0, rdy}, 1);
        acc(1, 0, 4'h2, 0, 0, 16'h5AEF, "R11 read with low-active ready");
        check("R11 low-active ready level", {31'h0, last_rdy}, 0);
        rdy_pol = 1;
        @(negedge clk);
        check("R11 high-active idle level", {31'h0, rdy}, 0);

        // DMA request and end of process
        dma_need = 1;
        @(negedge clk);
        check("R12 dreq follows need", {31'h0, dreq}, 1);
        eop_n = 0;
        @(negedge clk);
        eop_n = 1;
        check("R12 dreq dropped", {31'h0, dreq}, 0);
        repeat (3) @(negedge clk);
        check("R12 dreq stays low", {31'h0, dreq}, 0);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule